// File: doc/BRIEF.md
# Single-Qubit Gate Datapath

This block updates the state of one qubit by one gate. The state is two complex amplitudes, alpha and beta. The real and imaginary parts of each amplitude are signed 16-bit Q1.14 words, so the state is four words in all. The caller presents the four words, a gate opcode and, when the gate needs them, phase operands. It then raises `start` for one cycle. A one-cycle `done` strobe marks the cycle in which the four result words are valid. The results stay on the outputs until the next `done`.

The gates fall into two classes:
- **Arithmetic gates** use four multipliers, then a sum/round/saturate stage, and take two cycles.
  - The Hadamard gate mixes alpha and beta.
  - The two phase gates rotate beta by a unit complex phase. The caller supplies that phase as cosine and sine words, or a built-in eight-entry table supplies it from an index.
- **Swap gates** need no multiplier and finish in one cycle. They only exchange coefficients, swap real and imaginary parts and negate.

Top module: `qubit_gate`

## Requirements
- R1: After reset, all four result outputs are 0 and `done` and `busy` are 0.
- R2: Opcode 0 (Hadamard) gives alpha' = k·(alpha+beta) and beta' = k·(alpha−beta), one component at a time, with k = 0x2D41 (11585) in Q1.14.
- R3: Opcode 1 (phase by inputs) leaves alpha unchanged and gives beta' = beta·(c + i·s). Here c is `cos_in` and s is `sin_in`, both Q1.14. The result is re = br·c − bi·s and im = br·s + bi·c.
- R4: Opcode 2 (indexed phase) uses the same arithmetic as R3. For `jsel` from 1 to 8, c and s are cos(2π/2^j) and sin(2π/2^j), each scaled by 16384 and rounded to the nearest integer.
- R5: Opcode 2 with `jsel` equal to 0 or from 9 to 15 returns the input state unchanged.
- R6: Every arithmetic result is the full product sum plus 8192, shifted right arithmetically by 14 (round to nearest, ties upward), then clamped to the range −32768..32767.
- R7: Opcode 3 (X) exchanges alpha and beta.
- R8: Opcode 4 (Y) gives alpha' = −i·beta and beta' = i·alpha. That is a_re' = b_im, a_im' = −b_re, b_re' = −a_im and b_im' = a_re.
- R9: Opcode 5 (Z) leaves alpha unchanged and negates both parts of beta. Every negation in R8 and R9 maps −32768 to 32767.
- R10: For opcodes 0–2, `done` rises two cycles after the `start` sample, and `busy` is high for the cycle in between. For opcodes 3–7, `done` rises one cycle after the `start` sample. `done` lasts one cycle for each operation, and the outputs change only when `done` is high.
- R11: A `start` while `busy` is high is ignored: it gives no extra `done`, and the result is that of the running operation. The operands are captured in the cycle `start` is accepted.
- R12: Opcodes 6 and 7 return the input state unchanged after one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch strobe |
| op | input | 3 | Gate opcode |
| jsel | input | JW (4) | Table index for opcode 2 |
| cos_in | input | W (16) | Phase cosine for opcode 1, Q1.14 |
| sin_in | input | W (16) | Phase sine for opcode 1, Q1.14 |
| a_re | input | W (16) | Alpha real part |
| a_im | input | W (16) | Alpha imaginary part |
| b_re | input | W (16) | Beta real part |
| b_im | input | W (16) | Beta imaginary part |
| busy | output | 1 | Arithmetic operation in flight |
| done | output | 1 | Result valid strobe |
| a_re_o | output | W (16) | Result alpha real part |
| a_im_o | output | W (16) | Result alpha imaginary part |
| b_re_o | output | W (16) | Result beta real part |
| b_im_o | output | W (16) | Result beta imaginary part |

## Verification
The bench builds the block with its default parameters: 16-bit words, 14 fraction bits and a 4-bit table index. With these, the full signed word range can be driven, so the −32768 negation and the clamp in both directions are reached directly. The 4-bit index also covers every valid table row and every out-of-range index. Random opcodes and operands are mixed with directed cases: saturating Hadamard sums, a half-turn phase on −32768, and a start issued during the busy cycle.

// File: rtl/qubit_gate.sv
module qubit_gate #(
  parameter int W  = 16,
  parameter int F  = 14,
  parameter int JW = 4,
  parameter logic signed [W-1:0] INV_SQRT2 = 16'sh2D41
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [2:0]          op,
  input  logic [JW-1:0]       jsel,
  input  logic signed [W-1:0] cos_in,
  input  logic signed [W-1:0] sin_in,
  input  logic signed [W-1:0] a_re,
  input  logic signed [W-1:0] a_im,
  input  logic signed [W-1:0] b_re,
  input  logic signed [W-1:0] b_im,
  output logic                busy,
  output logic                done,
  output logic signed [W-1:0] a_re_o,
  output logic signed [W-1:0] a_im_o,
  output logic signed [W-1:0] b_re_o,
  output logic signed [W-1:0] b_im_o
);
  localparam int PW = 2 * W;
  localparam int SW = PW + 1;
  localparam int HALF = 1 << (F - 1);
  localparam logic signed [W-1:0] MAXW = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MINW = {1'b1, {(W-1){1'b0}}};
  localparam logic signed [SW-1:0] MAXS = SW'(MAXW);
  localparam logic signed [SW-1:0] MINS = SW'(MINW);
  localparam logic [2:0] OP_H = 3'd0, OP_PS = 3'd1, OP_RJ = 3'd2,
                         OP_X = 3'd3, OP_Y = 3'd4, OP_Z = 3'd5;

  function automatic logic signed [W-1:0] rnd_sat(input logic signed [SW-1:0] v);
    logic signed [SW-1:0] t;
    t = (v + SW'(HALF)) >>> F;
    if (t > MAXS) return MAXW;
    if (t < MINS) return MINW;
    return t[W-1:0];
  endfunction

  function automatic logic signed [W-1:0] neg_sat(input logic signed [W-1:0] v);
    return (v == MINW) ? MAXW : -v;
  endfunction

  logic signed [W-1:0] pc, ps;
  always_comb begin
    pc = W'(1 << F);
    ps = '0;
    if (op == OP_PS) begin
      pc = cos_in;
      ps = sin_in;
    end else begin
      case (jsel)
        JW'(1): begin pc = W'(-16384); ps = W'(0);     end
        JW'(2): begin pc = W'(0);      ps = W'(16384); end
        JW'(3): begin pc = W'(11585);  ps = W'(11585); end
        JW'(4): begin pc = W'(15137);  ps = W'(6270);  end
        JW'(5): begin pc = W'(16069);  ps = W'(3196);  end
        JW'(6): begin pc = W'(16305);  ps = W'(1606);  end
        JW'(7): begin pc = W'(16364);  ps = W'(804);   end
        JW'(8): begin pc = W'(16379);  ps = W'(402);   end
        default: ;
      endcase
    end
  end

  wire is_h    = (op == OP_H);
  wire slow_op = (op == OP_H) || (op == OP_PS) || (op == OP_RJ);
  wire accept  = start && !busy;

  wire signed [W-1:0] x0 = is_h ? a_re : b_re;
  wire signed [W-1:0] y0 = is_h ? INV_SQRT2 : pc;
  wire signed [W-1:0] x1 = is_h ? b_re : b_im;
  wire signed [W-1:0] y1 = is_h ? INV_SQRT2 : ps;
  wire signed [W-1:0] x2 = is_h ? a_im : b_re;
  wire signed [W-1:0] y2 = is_h ? INV_SQRT2 : ps;
  wire signed [W-1:0] x3 = is_h ? b_im : b_im;
  wire signed [W-1:0] y3 = is_h ? INV_SQRT2 : pc;

  logic signed [PW-1:0] p0, p1, p2, p3;
  logic signed [W-1:0]  ar_q, ai_q;
  logic                 h_q;

  wire signed [SW-1:0] e0 = SW'(p0), e1 = SW'(p1), e2 = SW'(p2), e3 = SW'(p3);
  wire signed [W-1:0] s_are = h_q ? rnd_sat(e0 + e1) : ar_q;
  wire signed [W-1:0] s_aim = h_q ? rnd_sat(e2 + e3) : ai_q;
  wire signed [W-1:0] s_bre = rnd_sat(e0 - e1);
  wire signed [W-1:0] s_bim = h_q ? rnd_sat(e2 - e3) : rnd_sat(e2 + e3);

  logic signed [W-1:0] f_are, f_aim, f_bre, f_bim;
  always_comb begin
    f_are = a_re; f_aim = a_im; f_bre = b_re; f_bim = b_im;
    case (op)
      OP_X: begin f_are = b_re; f_aim = b_im; f_bre = a_re; f_bim = a_im; end
      OP_Y: begin
        f_are = b_im;          f_aim = neg_sat(b_re);
        f_bre = neg_sat(a_im); f_bim = a_re;
      end
      OP_Z: begin f_bre = neg_sat(b_re); f_bim = neg_sat(b_im); end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; h_q <= 1'b0;
      p0 <= '0; p1 <= '0; p2 <= '0; p3 <= '0;
      ar_q <= '0; ai_q <= '0;
      a_re_o <= '0; a_im_o <= '0; b_re_o <= '0; b_im_o <= '0;
    end else begin
      done <= 1'b0;
      busy <= accept && slow_op;
      if (accept && slow_op) begin
        p0 <= PW'(x0) * PW'(y0);
        p1 <= PW'(x1) * PW'(y1);
        p2 <= PW'(x2) * PW'(y2);
        p3 <= PW'(x3) * PW'(y3);
        ar_q <= a_re; ai_q <= a_im; h_q <= is_h;
      end
      if (busy) begin
        a_re_o <= s_are; a_im_o <= s_aim; b_re_o <= s_bre; b_im_o <= s_bim;
        done <= 1'b1;
      end else if (accept) begin
        if (!slow_op) begin
          a_re_o <= f_are; a_im_o <= f_aim; b_re_o <= f_bre; b_im_o <= f_bim;
          done <= 1'b1;
        end
      end
    end
  end

  // R10
  slow_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (done && !busy));
  // R10
  fast_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !slow_op) |=> (done && !busy));
  // R11
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> !busy);
  // R10
  hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(a_re_o) && $stable(a_im_o) && $stable(b_re_o) && $stable(b_im_o)));
  // R10
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(busy) || $past(start)));
endmodule

// File: tb/qubit_gate_test.sv
module qubit_gate_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, start, busy, done;
  logic [2:0] op;
  logic [3:0] jsel;
  logic signed [15:0] cos_in, sin_in, a_re, a_im, b_re, b_im;
  logic signed [15:0] a_re_o, a_im_o, b_re_o, b_im_o;

  qubit_gate uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .jsel(jsel),
    .cos_in(cos_in), .sin_in(sin_in), .a_re(a_re), .a_im(a_im),
    .b_re(b_re), .b_im(b_im), .busy(busy), .done(done),
    .a_re_o(a_re_o), .a_im_o(a_im_o), .b_re_o(b_re_o), .b_im_o(b_im_o)
  );

  int total = 0, bad = 0;
  int cos_t[9], sin_t[9];

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int sat(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic int rs(longint v);
    return sat((v + 8192) >>> 14);
  endfunction

  function automatic int ng(int v);
    return sat(-longint'(v));
  endfunction

  function automatic int r16();
    logic [15:0] x;
    x = 16'($urandom);
    return int'($signed(x));
  endfunction

  function automatic string tag_of(int o, int j);
    case (o)
      0: return "R2";
      1: return "R3";
      2: return (j >= 1 && j <= 8) ? "R4" : "R5";
      3: return "R7";
      4: return "R8";
      5: return "R9";
      default: return "R12";
    endcase
  endfunction

  task automatic model(input int o, j, c, s, ar, ai, br, bi,
                       output int er, ei, fr, fi, lat);
    longint k = 11585;
    int pc, ps;
    er = ar; ei = ai; fr = br; fi = bi; lat = 1;
    case (o)
      0: begin
        lat = 2;
        er = rs(ar*k + br*k); fr = rs(ar*k - br*k);
        ei = rs(ai*k + bi*k); fi = rs(ai*k - bi*k);
      end
      1, 2: begin
        lat = 2;
        if (o == 1) begin pc = c; ps = s; end
        else if (j >= 1 && j <= 8) begin pc = cos_t[j]; ps = sin_t[j]; end
        else begin pc = 16384; ps = 0; end
        fr = rs(longint'(br)*pc - longint'(bi)*ps);
        fi = rs(longint'(br)*ps + longint'(bi)*pc);
      end
      3: begin er = br; ei = bi; fr = ar; fi = ai; end
      4: begin er = bi; ei = ng(br); fr = ng(ai); fi = ar; end
      5: begin fr = ng(br); fi = ng(bi); end
      default: ;
    endcase
  endtask

  task automatic run(int o, j, c, s, ar, ai, br, bi);
    int er, ei, fr, fi, lat, got;
    string t;
    t = tag_of(o, j);
    model(o, j, c, s, ar, ai, br, bi, er, ei, fr, fi, lat);
    @(negedge clk);
    op = 3'(o); jsel = 4'(j); cos_in = 16'(c); sin_in = 16'(s);
    a_re = 16'(ar); a_im = 16'(ai); b_re = 16'(br); b_im = 16'(bi);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got = 1;
    while (!done && got < 5) begin
      @(negedge clk);
      got++;
    end
    check("R10", {t, " latency"}, got, lat);
    check(t, "a_re", int'(a_re_o), er);
    check(t, "a_im", int'(a_im_o), ei);
    check(t, "b_re", int'(b_re_o), fr);
    check(t, "b_im", int'(b_im_o), fi);
    @(negedge clk);
    check("R10", "done one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int er, ei, fr, fi, lat;
    void'($urandom(32'd2024));
    for (int j = 1; j <= 8; j++) begin
      real ang;
      ang = 2.0 * 3.14159265358979 / (2.0 ** j);
      cos_t[j] = int'($cos(ang) * 16384.0);
      sin_t[j] = int'($sin(ang) * 16384.0);
    end
    rst_n = 1'b0; start = 1'b0; op = '0; jsel = '0;
    cos_in = '0; sin_in = '0; a_re = '0; a_im = '0; b_re = '0; b_im = '0;
    repeat (3) @(negedge clk);
    check("R1", "a_re", int'(a_re_o), 0);
    check("R1", "a_im", int'(a_im_o), 0);
    check("R1", "b_re", int'(b_re_o), 0);
    check("R1", "b_im", int'(b_im_o), 0);
    check("R1", "done", int'(done), 0);
    check("R1", "busy", int'(busy), 0);
    rst_n = 1'b1;

    run(0, 0, 0, 0, 16384, 0, 0, 0);
    run(0, 0, 0, 0, 32767, 32767, -32768, 32767);      // R6 upper clamp on sums
    run(0, 0, 0, 0, -32768, -32768, -32768, 32767);    // R6 lower clamp
    run(1, 0, 0, 16384, 1000, -2000, 3000, -4000);
    run(1, 0, 11585, -11585, 5, 6, -12345, 23456);
    for (int j = 0; j < 16; j++) run(2, j, 0, 0, 1234, -4321, 16384, -8000);
    run(2, 1, 0, 0, 7, 8, -32768, -32768);              // R6 half turn clamps to 32767
    run(1, 0, 1, 0, 0, 0, 8192, -8192);                // R6 tie rounding: 0.5 -> 1, -0.5 -> 0
    run(3, 0, 0, 0, 1, 2, 3, 4);
    run(4, 0, 0, 0, -32768, 100, -32768, -200);        // R8 negation of -32768
    run(5, 0, 0, 0, 11, 22, -32768, 32767);            // R9
    run(6, 0, 0, 0, 9, -9, 99, -99);
    run(7, 3, 0, 0, -1, 1, 2, -2);

    // R11: start during busy is ignored
    model(0, 0, 0, 0, 2000, 3000, -1000, 500, er, ei, fr, fi, lat);
    @(negedge clk);
    op = 3'd0; a_re = 16'sd2000; a_im = 16'sd3000; b_re = -16'sd1000; b_im = 16'sd500;
    start = 1'b1;
    @(negedge clk);
    check("R11", "busy in flight", int'(busy), 1);
    op = 3'd3; a_re = 16'sd7; a_im = 16'sd7; b_re = 16'sd7; b_im = 16'sd7;
    @(negedge clk);
    start = 1'b0;
    check("R11", "done", int'(done), 1);
    check("R11", "a_re", int'(a_re_o), er);
    check("R11", "a_im", int'(a_im_o), ei);
    check("R11", "b_re", int'(b_re_o), fr);
    check("R11", "b_im", int'(b_im_o), fi);
    @(negedge clk);
    check("R11", "no extra done", int'(done), 0);
    check("R11", "held a_re", int'(a_re_o), er);
    repeat (2) @(negedge clk);
    check("R11", "still no done", int'(done), 0);

    for (int n = 0; n < 400; n++) begin
      int o, j;
      o = int'($urandom_range(7, 0));
      j = int'($urandom_range(15, 0));
      run(o, j, r16(), r16(), r16(), r16(), r16(), r16());
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule